// File: doc/BRIEF.md
# Two-Bank Edge/Level Interrupt Controller

The block collects up to 64 interrupt source lines into one request for the CPU. The sources are split into two banks of 32. Each bank has four 32-bit registers: a latched-event register, an enable mask, a write-one-to-clear acknowledge register and a raw line readback register. Software reaches them through a plain register port with byte-address decode inside a 64-byte window.

Each source is fixed as level-sensitive or edge-triggered by a parameter mask. An edge-triggered source latches a rising edge into its event bit only while it is enabled. The bit stays set until it is acknowledged. A level-sensitive source never latches. It requests service for as long as its line is high and it is enabled.

The CPU request is the OR of all enabled pending sources, registered once. Priority selection, vectoring and cascading are left to software, which scans the event and line registers.

Top module: `ic_banked`

## Requirements
- R1: After reset all enable bits and event bits read as zero and `irq_o` is low.
- R2: Sources 0–31 sit in the bank at window offset 0x20 and sources 32–63 in the bank at 0x10. Within a bank, offset +0x0 is the event register, +0x4 enable, +0x8 acknowledge and +0xC line level. Bit n of each register belongs to source n of that bank. Address bits [1:0] are ignored.
- R3: A rising edge on an enabled edge-triggered source sets its event bit, readable after the next clock edge. The bit stays set until acknowledged.
- R4: A rising edge on a disabled source sets nothing.
- R5: Setting the enable bit of an edge-triggered source whose line is already high neither sets its event bit nor raises `irq_o`.
- R6: Writing 1 to a bit of the acknowledge register clears that event bit. Bits written as 0 leave their event bits unchanged, and the acknowledge register reads as zero.
- R7: When an acknowledge of a bit and a new enabled rising edge of the same source share a clock edge, the event bit remains set.
- R8: Sources whose bit is 1 in `LEVEL_MASK` (default: bank at 0x20 bits 20–28, other bank none) never set event bits. While enabled and high they hold `irq_o` high, and `irq_o` falls one cycle after the line drops.
- R9: The level register returns the current state of each source line regardless of its enable bit.
- R10: The enable register reads back exactly the last value written.
- R11: `irq_o` is the registered OR over all sources of (event, or line for level sources) AND enable. It rises one clock after the event bit becomes visible.
- R12: One cycle after every enable register holds zero, `irq_o` is low and stays low.
- R13: Offsets 0x00–0x0F and 0x30–0x3F read as zero, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 6 | Byte address inside the window |
| we_i | input | 1 | Write strobe for the addressed register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data of the addressed register (combinational) |
| src_i | input | 64 | Interrupt source lines, bit n is source n |
| irq_o | output | 1 | Registered combined interrupt request |

## Verification
The hardest state to reach is an acknowledge write that lands on the same clock edge as a fresh rising edge of the same source. The bench hand-drives that cycle. It first latches and clears the source, drops its line for a cycle, and then raises the line on the same falling edge that starts the acknowledge write. A second subtle case is enabling a source whose line is already high. Here the line is raised first and held, and only then is the enable written. The bench then confirms over two cycles that neither the event bit nor `irq_o` moves.

// File: rtl/ic_pkg.sv
package ic_pkg;
  localparam int unsigned BANK_W    = 32;
  localparam int unsigned SPAN      = 16;  // bytes per bank

  typedef enum logic [1:0] {
    REG_EVENT  = 2'd0,
    REG_ENABLE = 2'd1,
    REG_ACK    = 2'd2,
    REG_LEVEL  = 2'd3
  } reg_sel_e;

  // bank 0 sits highest, later banks step down by one span
  function automatic int unsigned bank_base(int unsigned num_banks, int unsigned b);
    return (num_banks - b) * SPAN;
  endfunction
endpackage

// File: rtl/ic_decode.sv
module ic_decode
  import ic_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 2,
  parameter int unsigned ADDR_W    = 6
) (
  input  logic [ADDR_W-1:0]    addr_i,
  output logic [NUM_BANKS-1:0] hit_o,
  output reg_sel_e             sel_o
);
  localparam int unsigned LO = $clog2(SPAN);

  assign sel_o = reg_sel_e'(addr_i[3:2]);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_hit
    localparam logic [ADDR_W-1:0] BASE = ADDR_W'(bank_base(NUM_BANKS, b));
    assign hit_o[b] = (addr_i[ADDR_W-1:LO] == BASE[ADDR_W-1:LO]);
  end
endmodule

// File: rtl/ic_bank.sv
module ic_bank
  import ic_pkg::*;
#(
  parameter int unsigned W        = 32,
  parameter logic [W-1:0] LVL_MASK = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lines_i,
  input  logic         hit_i,
  input  logic         we_i,
  input  reg_sel_e     sel_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] rdata_o,
  output logic         req_o
);
  logic [W-1:0] line_q, event_q, enable_q;
  logic [W-1:0] rise, set_ev, ack_bits;
  logic         en_we;

  assign rise     = lines_i & ~line_q;
  assign set_ev   = rise & enable_q & ~LVL_MASK;
  assign ack_bits = (hit_i && we_i && sel_i == REG_ACK) ? wdata_i : '0;
  assign en_we    = hit_i && we_i && sel_i == REG_ENABLE;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q   <= '0;
      event_q  <= '0;
      enable_q <= '0;
    end else begin
      line_q  <= lines_i;
      // new edge wins over a same-cycle ack
      event_q <= (event_q & ~ack_bits) | set_ev;
      if (en_we) enable_q <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (hit_i) begin
      unique case (sel_i)
        REG_EVENT:  rdata_o = event_q;
        REG_ENABLE: rdata_o = enable_q;
        REG_ACK:    rdata_o = '0;
        REG_LEVEL:  rdata_o = lines_i;
        default:    rdata_o = '0;
      endcase
    end
  end

  assign req_o = |((event_q | (lines_i & LVL_MASK)) & enable_q);

  // an event bit only drops after an ack of that bit
  assert_hold_until_ack_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((~event_q & $past(event_q) & ~$past(ack_bits)) == '0));
  // a newly set event bit must have been enabled
  assert_disabled_ignored_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((event_q & ~$past(event_q) & ~$past(enable_q)) == '0));
  // edge captured in the ack cycle survives
  assert_edge_beats_ack_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(set_ev) & ~event_q) == '0));
  assert_level_no_latch_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((event_q & LVL_MASK) == '0));
  assert_enable_readback_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_we |=> (enable_q == $past(wdata_i)));
  assert_no_req_when_masked_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_q == '0) |-> !req_o);
endmodule

// File: rtl/ic_banked.sv
module ic_banked
  import ic_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 2,
  parameter logic [NUM_BANKS*BANK_W-1:0] LEVEL_MASK = 64'h0000_0000_1ff0_0000,
  localparam int unsigned ADDR_W = $clog2(SPAN * (NUM_BANKS + 2)),
  localparam int unsigned NSRC   = NUM_BANKS * BANK_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [BANK_W-1:0] wdata_i,
  output logic [BANK_W-1:0] rdata_o,
  input  logic [NSRC-1:0]   src_i,
  output logic              irq_o
);
  logic [NUM_BANKS-1:0] hit, req;
  reg_sel_e             sel;
  logic [BANK_W-1:0]    bank_rd [NUM_BANKS];
  logic                 irq_q;

  ic_decode #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) u_decode (
    .addr_i (addr_i),
    .hit_o  (hit),
    .sel_o  (sel)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    ic_bank #(.W(BANK_W), .LVL_MASK(LEVEL_MASK[b*BANK_W +: BANK_W])) u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .lines_i (src_i[b*BANK_W +: BANK_W]),
      .hit_i   (hit[b]),
      .we_i    (we_i),
      .sel_i   (sel),
      .wdata_i (wdata_i),
      .rdata_o (bank_rd[b]),
      .req_o   (req[b])
    );
  end

  always_comb begin
    rdata_o = '0;
    for (int b = 0; b < NUM_BANKS; b++) rdata_o |= bank_rd[b];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |req;
  end
  assign irq_o = irq_q;

  assert_unmapped_reads_zero_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit == '0) |-> (rdata_o == '0));
  assert_one_bank_hit_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit));
endmodule

// File: tb/ic_banked_bench.sv
module ic_banked_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [63:0] src = '0;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ic_banked u_ic_banked (
    .clk_i (clk), .rst_ni (rst_n), .addr_i (addr), .we_i (we),
    .wdata_i (wdata), .rdata_o (rdata), .src_i (src), .irq_o (irq)
  );

  localparam logic [5:0] EV0 = 6'h20, EN0 = 6'h24, AK0 = 6'h28, LV0 = 6'h2C;
  localparam logic [5:0] EV1 = 6'h10, EN1 = 6'h14, AK1 = 6'h18, LV1 = 6'h1C;

  // {bank, bit, enable, expect_event}
  localparam logic [7:0] VEC [0:8] = '{
    {1'b0, 5'd3,  1'b1, 1'b1},
    {1'b0, 5'd3,  1'b0, 1'b0},
    {1'b1, 5'd7,  1'b1, 1'b1},
    {1'b1, 5'd31, 1'b0, 1'b0},
    {1'b0, 5'd0,  1'b1, 1'b1},
    {1'b1, 5'd20, 1'b1, 1'b1},
    {1'b0, 5'd20, 1'b1, 1'b0},
    {1'b0, 5'd30, 1'b1, 1'b1},
    {1'b0, 5'd29, 1'b1, 1'b1}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    addr = a; we = 1'b0;
    #1 d = rdata;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(EN0, v); chk("R1 enable0", v, 0);
    rd(EN1, v); chk("R1 enable1", v, 0);
    rd(EV0, v); chk("R1 event0", v, 0);
    rd(EV1, v); chk("R1 event1", v, 0);
    chk("R1 irq", {31'd0, irq}, 0);

    // R3/R4/R8 vector walk
    foreach (VEC[i]) begin
      logic        bk = VEC[i][7];
      logic [4:0]  bt = VEC[i][6:2];
      logic        en = VEC[i][1];
      logic        ex = VEC[i][0];
      logic [31:0] m  = 32'd1 << bt;
      wr(bk ? EN1 : EN0, en ? m : 32'd0);
      src[{bk, bt}] = 1'b1;
      @(negedge clk);
      src[{bk, bt}] = 1'b0;
      @(negedge clk);
      rd(bk ? EV1 : EV0, v);
      chk(en ? "R3 vector event" : "R4 vector event", v, ex ? m : 32'd0);
      chk("R11 vector irq", {31'd0, irq}, {31'd0, ex});
      wr(bk ? AK1 : AK0, 32'hFFFF_FFFF);
      wr(bk ? EN1 : EN0, 32'd0);
      @(negedge clk);
    end

    // R5 enable while line already high
    src[5] = 1'b1;
    repeat (2) @(negedge clk);
    wr(EN0, 32'h20);
    repeat (2) @(negedge clk);
    rd(EV0, v); chk("R5 event", v, 0);
    chk("R5 irq", {31'd0, irq}, 0);
    src[5] = 1'b0;
    wr(EN0, 32'd0);

    // R6 selective ack, zero bits, ack readback
    wr(EN0, 32'h18);
    src[3] = 1'b1; src[4] = 1'b1;
    @(negedge clk);
    src[3] = 1'b0; src[4] = 1'b0;
    wr(AK0, 32'h08);
    rd(EV0, v); chk("R6 partial ack", v, 32'h10);
    wr(AK0, 32'h0);
    rd(EV0, v); chk("R6 zero ack", v, 32'h10);
    rd(AK0, v); chk("R6 ack reads zero", v, 0);
    wr(AK0, 32'h10);
    rd(EV0, v); chk("R6 full ack", v, 0);
    wr(EN0, 32'd0);

    // R7 ack and new edge in the same cycle
    wr(EN0, 32'h200);
    src[9] = 1'b1;
    @(negedge clk);
    src[9] = 1'b0;
    @(negedge clk);
    addr = AK0; wdata = 32'h200; we = 1'b1; src[9] = 1'b1;
    @(negedge clk);
    we = 1'b0;
    rd(EV0, v); chk("R7 event kept", v, 32'h200);
    src[9] = 1'b0;
    wr(AK0, 32'h200);
    wr(EN0, 32'd0);
    @(negedge clk);

    // R8 level source drives irq while high
    wr(EN0, 32'h0040_0000);
    src[22] = 1'b1;
    @(negedge clk);
    chk("R8 level irq high", {31'd0, irq}, 1);
    rd(EV0, v); chk("R8 level no event", v, 0);
    src[22] = 1'b0;
    @(negedge clk);
    chk("R8 level irq falls", {31'd0, irq}, 0);
    wr(EN0, 32'd0);

    // R9 raw level readback, R4 edges while disabled
    src = 64'hA5A5_0F0F_1234_5678;
    @(negedge clk);
    rd(LV0, v); chk("R9 level0", v, 32'h1234_5678);
    rd(LV1, v); chk("R9 level1", v, 32'hA5A5_0F0F);
    @(negedge clk);
    rd(EV0, v); chk("R4 event0 disabled", v, 0);
    rd(EV1, v); chk("R4 event1 disabled", v, 0);
    src = '0;
    @(negedge clk);

    // R10 enable readback, R2 low address bits ignored
    wr(EN1, 32'hDEAD_BEEF);
    rd(EN1, v); chk("R10 enable1", v, 32'hDEAD_BEEF);
    rd(6'h17, v); chk("R2 unaligned", v, 32'hDEAD_BEEF);
    rd(EN0, v); chk("R2 bank0 separate", v, 0);
    wr(EN1, 32'd0);

    // R11 latency, R12 masking
    wr(EN1, 32'h2);
    src[33] = 1'b1;
    @(negedge clk);
    rd(EV1, v); chk("R11 event visible", v, 32'h2);
    chk("R11 irq not yet", {31'd0, irq}, 0);
    @(negedge clk);
    chk("R11 irq raised", {31'd0, irq}, 1);
    src[33] = 1'b0;
    wr(EN1, 32'd0);
    @(negedge clk);
    chk("R12 irq masked", {31'd0, irq}, 0);
    repeat (2) @(negedge clk);
    chk("R12 irq stays low", {31'd0, irq}, 0);
    wr(AK1, 32'h2);

    // R13 unmapped
    wr(6'h04, 32'hFFFF_FFFF);
    wr(6'h34, 32'hFFFF_FFFF);
    rd(6'h04, v); chk("R13 read 0x04", v, 0);
    rd(6'h34, v); chk("R13 read 0x34", v, 0);
    rd(6'h3C, v); chk("R13 read 0x3C", v, 0);
    rd(EN0, v); chk("R13 enable0 untouched", v, 0);
    rd(EN1, v); chk("R13 enable1 untouched", v, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule